// File: doc/BRIEF.md
# DDR Memory Start-Up Command Sequencer

This block sits on the controller side of a DDR SDRAM interface. It produces the command sequence the memory needs after power is applied. From reset it keeps the clock-enable pin low for a programmable stable-clock interval. It then raises clock enable with one idle command and walks a fixed script:

- precharge of every bank;
- extended mode write that turns the delay-locked loop on;
- mode write that resets that loop;
- a second precharge of every bank;
- a programmable number of auto refreshes;
- a closing mode write that keeps the operating fields without another loop reset.

Each command is followed by its own minimum spacing, counted in clocks. Every cycle that carries no command drives an idle command. A done flag rises once the script is finished and the lock interval that follows the loop reset has run out.

The burst length, burst order, read latency and drive strength fields come in as plain level inputs. The block copies them onto the address bus during the mode writes. All outputs are plain control pins. There is no handshake: the memory accepts one command per clock, and the script is fixed.

Top module: `ddr_init_seq`

## Requirements
- R1: From reset, `cke` is low and the command pins carry idle ({cs_n,ras_n,cas_n,we_n} = 0111) for exactly T_STABLE cycles; after that `cke` stays high until the next reset.
- R2: The first cycle with `cke` high carries idle; the next cycle carries precharge-all, encoded 0010 with address bit 10 set and all other address bits and `ba` zero.
- R3: T_RP cycles after the first precharge, an extended mode write (0000) is issued with `ba` = 01, address bit 0 = 0 (loop on), address bit 1 = `drive_half`, and all other address bits zero.
- R4: T_MRD cycles after the extended write, a mode write (0000) is issued with `ba` = 00 and address bit 8 = 1. Address bits 2..0 carry `mode_bl`, bit 3 carries `mode_interleave`, bits 6..4 carry `mode_cas`, and all other bits are zero.
- R5: Any two mode register writes are at least T_MRD cycles apart.
- R6: T_MRD cycles after the loop-reset write, a second precharge-all is issued. T_RP cycles later the first of N_REF auto refreshes (0001, `ba` and address zero) is issued, and successive refreshes are T_RFC cycles apart.
- R7: T_RFC cycles after the last refresh, a closing mode write is issued with the same fields as R4 but address bit 8 = 0.
- R8: `init_done` rises one cycle after both of these hold: T_MRD cycles have passed since the closing write, and at least T_LOCK cycles have passed since the loop-reset write. It then stays high until reset.
- R9: Every cycle that carries no command drives idle (0111) with `ba` and address zero.
- R10: Asserting `rst_n` low at any point immediately forces `cke` low, idle on the command pins and `init_done` low; the script restarts from the beginning after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_bl | input | 3 | Burst length code for mode writes |
| mode_interleave | input | 1 | Burst order: 1 interleaved, 0 sequential |
| mode_cas | input | 3 | Read latency code for mode writes |
| drive_half | input | 1 | Output drive strength select for the extended write |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank / mode register select |
| addr | output | ADDR_W | Address and mode operand bus |
| init_done | output | 1 | Normal operation permitted |

## Verification
The assertions take for granted that every timing parameter is at least one and that the mode field inputs stay steady while the script runs. The sequencer copies those fields onto the bus in the cycle of each mode write, so both mode writes must see the same values. The stimulus changes the fields only while reset is held, and it runs the script twice with different field values. A second instance with a short lock interval makes the end of the script, rather than the lock count, decide when `init_done` rises.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [3:0] {
    ST_PWR,
    ST_NOP,
    ST_PALL1,
    ST_EMR,
    ST_MRR,
    ST_PALL2,
    ST_REF,
    ST_MRF,
    ST_DONE
  } step_t;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_MRS = 4'b0000;

endpackage

// File: rtl/ddr_init_gap_timer.sv
module ddr_init_gap_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         first,
  output logic         last
);
  logic [W-1:0] cnt;

  assign first = (cnt == '0);
  assign last  = (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (en) cnt <= last ? '0 : cnt + 1'b1;
  end

  // Count never runs past the current step's limit (spacing, R5)
  assert_gap_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt <= limit));

endmodule

// File: rtl/ddr_init_lock_timer.sv
module ddr_init_lock_timer #(
  parameter int LOCK = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ok
);
  localparam int LW = $clog2(LOCK + 1);

  logic [LW-1:0] cnt;
  logic          run;

  assign ok = run && (cnt >= LW'(LOCK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (start) begin
      cnt <= LW'(1);
      run <= 1'b1;
    end else if (run && cnt != LW'(LOCK)) begin
      cnt <= cnt + 1'b1;
    end
  end

  // Once the lock interval has run out it stays out (R8)
  assert_lock_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && !start) |=> ok);

endmodule

// File: rtl/ddr_init_cmd_decode.sv
module ddr_init_cmd_decode
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2
) (
  input  step_t             step,
  input  logic              fire,
  input  logic [2:0]        mode_bl,
  input  logic              mode_interleave,
  input  logic [2:0]        mode_cas,
  input  logic              drive_half,
  output logic [3:0]        cmd,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] mode_word;

  always_comb begin
    mode_word      = '0;
    mode_word[2:0] = mode_bl;
    mode_word[3]   = mode_interleave;
    mode_word[6:4] = mode_cas;
  end

  always_comb begin
    cmd  = CMD_NOP;
    ba   = '0;
    addr = '0;
    if (fire) begin
      case (step)
        ST_PALL1, ST_PALL2: begin
          cmd      = CMD_PRE;
          addr[10] = 1'b1;
        end
        ST_EMR: begin
          cmd     = CMD_MRS;
          ba      = BA_W'(1);
          addr[0] = 1'b0;
          addr[1] = drive_half;
        end
        ST_MRR: begin
          cmd     = CMD_MRS;
          addr    = mode_word;
          addr[8] = 1'b1;
        end
        ST_MRF: begin
          cmd  = CMD_MRS;
          addr = mode_word;
        end
        ST_REF:  cmd = CMD_REF;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int T_STABLE = 10000,
  parameter int T_RP     = 3,
  parameter int T_MRD    = 2,
  parameter int T_RFC    = 12,
  parameter int T_LOCK   = 200,
  parameter int N_REF    = 2,
  parameter int ADDR_W   = 12,
  parameter int BA_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_bl,
  input  logic              mode_interleave,
  input  logic [2:0]        mode_cas,
  input  logic              drive_half,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);
  localparam int MAXG = (T_STABLE > T_RP ? T_STABLE : T_RP) > (T_MRD > T_RFC ? T_MRD : T_RFC)
                      ? (T_STABLE > T_RP ? T_STABLE : T_RP) : (T_MRD > T_RFC ? T_MRD : T_RFC);
  localparam int GW   = $clog2(MAXG + 1);
  localparam int RW   = $clog2(N_REF + 1);
  localparam int DW   = $clog2(T_LOCK + 1);

  step_t         step;
  logic [GW-1:0] limit;
  logic          fire, last, advance, lock_ok;
  logic [RW-1:0] ref_idx;
  logic [3:0]    cmd;

  always_comb begin
    case (step)
      ST_PWR:                 limit = GW'(T_STABLE - 1);
      ST_PALL1, ST_PALL2:     limit = GW'(T_RP - 1);
      ST_EMR, ST_MRR, ST_MRF: limit = GW'(T_MRD - 1);
      ST_REF:                 limit = GW'(T_RFC - 1);
      default:                limit = '0;
    endcase
  end

  ddr_init_gap_timer #(.W(GW)) u_gap (
    .clk(clk), .rst_n(rst_n), .en(step != ST_DONE),
    .limit(limit), .first(fire), .last(last)
  );

  ddr_init_lock_timer #(.LOCK(T_LOCK)) u_lock (
    .clk(clk), .rst_n(rst_n), .start(step == ST_MRR && fire), .ok(lock_ok)
  );

  ddr_init_cmd_decode #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_dec (
    .step(step), .fire(fire), .mode_bl(mode_bl),
    .mode_interleave(mode_interleave), .mode_cas(mode_cas),
    .drive_half(drive_half), .cmd(cmd), .ba(ba), .addr(addr)
  );

  assign advance = last && (step != ST_DONE) &&
                   (step != ST_REF || ref_idx == RW'(N_REF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step      <= ST_PWR;
      ref_idx   <= '0;
      init_done <= 1'b0;
    end else begin
      if (advance) step <= step_t'(step + 4'd1);
      if (step == ST_REF && last) ref_idx <= ref_idx + 1'b1;
      if (step == ST_DONE && lock_ok) init_done <= 1'b1;
    end
  end

  assign cke = (step != ST_PWR);
  assign {cs_n, ras_n, cas_n, we_n} = cmd;

  // ---- checker state: spacing measured at the pins ----
  logic [GW-1:0] mrs_gap, ref_gap;
  logic          mrs_seen, ref_seen, dll_seen;
  logic [DW-1:0] dll_gap;
  logic          is_mrs, is_ref, is_dll_rst;

  assign is_mrs     = (cmd == CMD_MRS);
  assign is_ref     = (cmd == CMD_REF);
  assign is_dll_rst = is_mrs && (ba == '0) && addr[8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mrs_gap <= '0; ref_gap <= '0; dll_gap <= '0;
      mrs_seen <= 1'b0; ref_seen <= 1'b0; dll_seen <= 1'b0;
    end else begin
      if (is_mrs) begin mrs_seen <= 1'b1; mrs_gap <= GW'(1); end
      else if (mrs_gap != GW'(MAXG)) mrs_gap <= mrs_gap + 1'b1;
      if (is_ref) begin ref_seen <= 1'b1; ref_gap <= GW'(1); end
      else if (ref_gap != GW'(MAXG)) ref_gap <= ref_gap + 1'b1;
      if (is_dll_rst) begin dll_seen <= 1'b1; dll_gap <= DW'(1); end
      else if (dll_gap != DW'(T_LOCK)) dll_gap <= dll_gap + 1'b1;
    end
  end

  assert_cke_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);
  assert_idle_while_cke_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (cmd == CMD_NOP));
  assert_mrd_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mrs && mrs_seen) |-> (mrs_gap >= GW'(T_MRD)));
  assert_rfc_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref && ref_seen) |-> (ref_gap >= GW'(T_RFC)));
  assert_ready_after_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> (dll_seen && dll_gap >= DW'(T_LOCK)));
  assert_ready_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

endmodule

// File: tb/ddr_init_seq_bench.sv
module ddr_init_seq_bench;
  localparam int T_STABLE = 20, T_RP = 3, T_MRD = 2, T_RFC = 5, N_REF = 2;
  localparam int READY_MAIN = 57;  // loop-reset write at 26, lock 30, +1 register
  localparam int READY_FAST = 44;  // script ends at 43, +1 register
  localparam int NEVT = 7;
  // {cycle, kind}: 0 pre1, 1 ext write, 2 loop-reset write, 3 pre2, 4 refresh, 5 closing write
  localparam logic [10:0] EVT [NEVT] = '{
    {8'd21, 3'd0}, {8'd24, 3'd1}, {8'd26, 3'd2}, {8'd28, 3'd3},
    {8'd31, 3'd4}, {8'd36, 3'd4}, {8'd41, 3'd5}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bl, cas;
  logic bt, drv;
  logic cke, cs_n, ras_n, cas_n, we_n, done;
  logic [1:0] ba;
  logic [11:0] addr;
  logic f_cke, f_cs_n, f_ras_n, f_cas_n, f_we_n, f_done;
  logic [1:0] f_ba;
  logic [11:0] f_addr;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ddr_init_seq #(.T_STABLE(T_STABLE), .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC),
                 .T_LOCK(30), .N_REF(N_REF)) u_ddr_init_seq (
    .clk(clk), .rst_n(rst_n), .mode_bl(bl), .mode_interleave(bt), .mode_cas(cas),
    .drive_half(drv), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .init_done(done));

  ddr_init_seq #(.T_STABLE(T_STABLE), .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC),
                 .T_LOCK(4), .N_REF(N_REF)) u_ddr_init_seq_fast (
    .clk(clk), .rst_n(rst_n), .mode_bl(bl), .mode_interleave(bt), .mode_cas(cas),
    .drive_half(drv), .cke(f_cke), .cs_n(f_cs_n), .ras_n(f_ras_n), .cas_n(f_cas_n),
    .we_n(f_we_n), .ba(f_ba), .addr(f_addr), .init_done(f_done));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // expected {cmd, ba, addr} for an event kind; 7 means idle
  function automatic logic [17:0] exp_word(input int kind);
    case (kind)
      0, 3:    return {4'b0010, 2'b00, 12'h400};
      1:       return {4'b0000, 2'b01, 10'b0, drv, 1'b0};
      2:       return {4'b0000, 2'b00, 3'b0, 1'b1, 1'b0, cas, bt, bl};
      4:       return {4'b0001, 2'b00, 12'h000};
      5:       return {4'b0000, 2'b00, 3'b0, 1'b0, 1'b0, cas, bt, bl};
      default: return {4'b0111, 2'b00, 12'h000};
    endcase
  endfunction

  function automatic string tag_of(input int kind);
    case (kind)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3, 4: return "R6";
      5: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic run_pass(input int ncyc);
    int last_mrs = -100;
    for (int c = 0; c < ncyc; c++) begin
      int kind = 7;
      for (int e = 0; e < NEVT; e++)
        if (int'(EVT[e][10:3]) == c) kind = int'(EVT[e][2:0]);
      chk("R1 cke", {31'b0, cke}, {31'b0, (c >= T_STABLE)});
      chk(tag_of(kind), {14'b0, cs_n, ras_n, cas_n, we_n, ba, addr}, {14'b0, exp_word(kind)});
      chk("R8 done", {31'b0, done}, {31'b0, (c >= READY_MAIN)});
      chk("R8 done fast", {31'b0, f_done}, {31'b0, (c >= READY_FAST)});
      if ({cs_n, ras_n, cas_n, we_n} == 4'b0000) begin
        if (last_mrs >= 0)
          chk("R5 mode write spacing", {31'b0, (c - last_mrs >= T_MRD)}, 32'd1);
        last_mrs = c;
      end
      @(negedge clk);
    end
  endtask

  task automatic chk_reset_state();
    chk("R10 cke", {31'b0, cke}, 32'd0);
    chk("R10 cmd", {28'b0, cs_n, ras_n, cas_n, we_n}, 32'h7);
    chk("R10 done", {30'b0, done, f_done}, 32'd0);
  endtask

  initial begin
    bl = 3'b011; bt = 1'b1; cas = 3'b011; drv = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_reset_state();
    rst_n = 1'b1;
    run_pass(70);  // full script, lock interval decides done; sticky to 70
    // mid-script reset (R10)
    rst_n = 1'b0;
    #1 chk_reset_state();
    @(negedge clk);
    rst_n = 1'b1;
    run_pass(25);
    rst_n = 1'b0;
    #1 chk_reset_state();
    bl = 3'b010; bt = 1'b0; cas = 3'b110; drv = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    run_pass(70);  // restarted script with new mode fields
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule